// File: doc/BRIEF.md
# Vulnerability-Ranked Shared FPU Allocator

A cluster of processor cores shares a small pool of floating-point pipelines. Each pipeline serves one operation kind, such as add or multiply. A core that needs a pipeline raises a request that names the operation kind and says whether the work is exact or approximate. An approximate request also carries an error-rate limit. Separately, a monitor measures how often each pipeline produces timing errors and publishes a vulnerability figure for every unit. The allocator ranks the units from least to most vulnerable. It then hands each request the least vulnerable free unit of the right kind, and tells the core which operating mode to program on that unit.

Only one request is served in each cycle. The cores take turns in round-robin order, so two cores are never handed the same pipeline. A granted unit stays allocated until its holder pulses the release line for it. When a request cannot be served, the core keeps it raised and it waits. A new set of vulnerability figures changes the ranking used for later grants. It never takes away a unit that is already allocated.

The grant is combinational from the request and the current state. The requesting core samples it at the clock edge and drops its request afterwards.

Top module: `fpu_alloc`

## Requirements
- R1: After reset no unit is held, no grant is given, and the ranking is plain index order: with no figures published, the lowest-indexed free unit of the requested kind wins.
- R2: A grant names the free unit of the requested kind that has the lowest last-published vulnerability.
- R3: When two units have equal vulnerability, the one with the lower index is preferred.
- R4: A unit is skipped when its external busy input is high or when it is already allocated.
- R5: A unit is granted only to a request whose 2-bit kind code equals that unit's kind code.
- R6: When no free unit of the requested kind exists, no grant is given to that core and its request stays pending. It is granted in the cycle after a unit of that kind is released.
- R7: The grant mode bit is 1 (approximate) only when the request is approximate and the unit's vulnerability is strictly below the request's threshold. Otherwise the mode bit is 0 (accurate). A vulnerability equal to the threshold gives accurate mode.
- R8: Among the cores whose requests can be served, the next grant goes to the first one found by searching upward, with wrap-around, from the core index after the last granted core.
- R9: At most one grant is issued per cycle, and a granted unit is not granted again until it is released.
- R10: Vulnerability figures presented with a publish pulse take effect from the next cycle. Publishing never frees or reassigns an allocated unit.
- R11: A release pulse on an allocated unit makes that unit available in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid_i | input | NUM_CORES | Per-core request, held until granted |
| req_kind_i | input | NUM_CORES*KIND_W | Per-core requested operation kind |
| req_approx_i | input | NUM_CORES | Per-core approximate-work flag |
| req_thresh_i | input | NUM_CORES*VULN_W | Per-core error-rate threshold |
| unit_kind_i | input | NUM_UNITS*KIND_W | Operation kind of each unit |
| unit_busy_i | input | NUM_UNITS | Externally busy units |
| vuln_i | input | NUM_UNITS*VULN_W | Measured vulnerability per unit |
| vuln_publish_i | input | 1 | Capture vuln_i and rebuild ranking |
| release_i | input | NUM_UNITS | Per-unit release pulse |
| gnt_valid_o | output | 1 | A grant is issued this cycle |
| gnt_core_o | output | CORE_W | Core receiving the grant |
| gnt_unit_o | output | UNIT_W | Unit allocated |
| gnt_approx_o | output | 1 | Mode to configure: 1 approximate, 0 accurate |

## Verification
Every cycle, the assertions check the following. A grant never lands on a busy or allocated unit. It always matches the requester's kind and goes to a core that is actually requesting. The approximate mode appears only for approximate requests. The ranking is kept sorted. An allocated unit stays allocated until released, whatever is published. Only the bench's scenarios can show that the least vulnerable unit is chosen and that ties go to the lower index. The same holds for the strict threshold boundary, the round-robin order across several waiting cores, and a pending request being served right after a release.

// File: rtl/fpa_pkg.sv
// Shared definitions for the FPU allocator.
// Assumes: nothing beyond IEEE 1800-2017.
package fpa_pkg;

    // Operating mode programmed on a granted unit.
    typedef enum logic {
        MODE_ACCURATE = 1'b0,
        MODE_APPROX   = 1'b1
    } fpa_mode_e;

    // Width helper that never returns zero.
    function automatic int safe_clog2(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/fpa_rank.sv
// Holds the last published vulnerability snapshot and derives the
// ascending ranking of units from it (ties go to the lower index).
// Assumes: publish is a single-cycle strobe; ranking is valid the cycle after.
module fpa_rank #(
    parameter int NUM_UNITS = 8,
    parameter int VULN_W    = 8,
    localparam int UNIT_W   = fpa_pkg::safe_clog2(NUM_UNITS)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        publish_i,
    input  logic [NUM_UNITS*VULN_W-1:0] vuln_i,
    output logic [NUM_UNITS*VULN_W-1:0] snap_o,
    output logic [NUM_UNITS*UNIT_W-1:0] order_o
);

    logic [VULN_W-1:0] snap_q [NUM_UNITS];
    logic [UNIT_W-1:0] pos    [NUM_UNITS];
    logic [UNIT_W-1:0] order  [NUM_UNITS];

    // Capture the published figures.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int u = 0; u < NUM_UNITS; u++) snap_q[u] <= '0;
        end else if (publish_i) begin
            for (int u = 0; u < NUM_UNITS; u++) snap_q[u] <= vuln_i[u*VULN_W +: VULN_W];
        end
    end

    // Position of each unit = number of units that sort ahead of it.
    always_comb begin
        for (int u = 0; u < NUM_UNITS; u++) begin
            int cnt;
            cnt = 0;
            for (int v = 0; v < NUM_UNITS; v++) begin
                if ((snap_q[v] < snap_q[u]) || ((snap_q[v] == snap_q[u]) && (v < u)))
                    cnt++;
            end
            pos[u] = UNIT_W'(cnt);
        end
    end

    // Invert positions into the ordered list.
    always_comb begin
        for (int p = 0; p < NUM_UNITS; p++) begin
            order[p] = '0;
            for (int u = 0; u < NUM_UNITS; u++) begin
                if (pos[u] == UNIT_W'(p)) order[p] = UNIT_W'(u);
            end
        end
    end

    // Flatten outputs.
    always_comb begin
        for (int u = 0; u < NUM_UNITS; u++) begin
            snap_o[u*VULN_W +: VULN_W]  = snap_q[u];
            order_o[u*UNIT_W +: UNIT_W] = order[u];
        end
    end

    // Neighbouring list entries must be in ascending vulnerability.
    for (genvar p = 0; p < NUM_UNITS - 1; p++) begin : g_sorted
        assert_rank_sorted_R2: assert property (@(posedge clk) disable iff (!rst_n)
            snap_q[order[p]] <= snap_q[order[p+1]]);
    end

endmodule

// File: rtl/fpa_rr.sv
// Round-robin choice of one core among those with a servable request.
// The search starts just above the last core granted and wraps around.
// Assumes: advance_i is high exactly when the chosen core is granted.
module fpa_rr #(
    parameter int NUM_CORES = 16,
    localparam int CORE_W   = fpa_pkg::safe_clog2(NUM_CORES)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_CORES-1:0] req_i,
    input  logic                 advance_i,
    output logic                 any_o,
    output logic [CORE_W-1:0]    idx_o
);

    logic [CORE_W-1:0]    last_q;
    logic [NUM_CORES-1:0] pick_vec;

    // Remember the most recently granted core.
    always_ff @(posedge clk) begin
        if (!rst_n)         last_q <= CORE_W'(NUM_CORES - 1);
        else if (advance_i) last_q <= idx_o;
    end

    // Find the first requesting core after last_q.
    always_comb begin
        any_o    = 1'b0;
        idx_o    = '0;
        pick_vec = '0;
        for (int i = 1; i <= NUM_CORES; i++) begin
            int c;
            c = (int'(last_q) + i) % NUM_CORES;
            if (!any_o && req_i[c]) begin
                any_o       = 1'b1;
                idx_o       = CORE_W'(c);
                pick_vec[c] = 1'b1;
            end
        end
    end

    assert_single_pick_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(pick_vec));
    assert_pick_requests_R8: assert property (@(posedge clk) disable iff (!rst_n)
        any_o |-> req_i[idx_o]);

endmodule

// File: rtl/fpa_walk.sv
// Walks the ranked list from the least vulnerable entry and returns the
// first unit that is eligible (free and of the right kind).
// Assumes: order_i is a permutation of unit indices.
module fpa_walk #(
    parameter int NUM_UNITS = 8,
    localparam int UNIT_W   = fpa_pkg::safe_clog2(NUM_UNITS)
) (
    input  logic [NUM_UNITS*UNIT_W-1:0] order_i,
    input  logic [NUM_UNITS-1:0]        elig_i,
    output logic                        found_o,
    output logic [UNIT_W-1:0]           unit_o
);

    // Stop at the first eligible entry of the ascending list.
    always_comb begin
        found_o = 1'b0;
        unit_o  = '0;
        for (int p = 0; p < NUM_UNITS; p++) begin
            logic [UNIT_W-1:0] u;
            u = order_i[p*UNIT_W +: UNIT_W];
            if (!found_o && elig_i[u]) begin
                found_o = 1'b1;
                unit_o  = u;
            end
        end
    end

endmodule

// File: rtl/fpu_alloc.sv
// Top of the shared-FPU allocator. It arbitrates the core requests that
// can be served, walks the vulnerability ranking for the winner's kind,
// marks the chosen unit allocated and reports the mode to program on it.
// Assumes: a core holds its request until it samples its own grant, and
// releases only units it holds.
module fpu_alloc #(
    parameter int NUM_CORES = 16,
    parameter int NUM_UNITS = 8,
    parameter int VULN_W    = 8,
    parameter int KIND_W    = 2,
    localparam int CORE_W   = fpa_pkg::safe_clog2(NUM_CORES),
    localparam int UNIT_W   = fpa_pkg::safe_clog2(NUM_UNITS)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [NUM_CORES-1:0]        req_valid_i,
    input  logic [NUM_CORES*KIND_W-1:0] req_kind_i,
    input  logic [NUM_CORES-1:0]        req_approx_i,
    input  logic [NUM_CORES*VULN_W-1:0] req_thresh_i,
    input  logic [NUM_UNITS*KIND_W-1:0] unit_kind_i,
    input  logic [NUM_UNITS-1:0]        unit_busy_i,
    input  logic [NUM_UNITS*VULN_W-1:0] vuln_i,
    input  logic                        vuln_publish_i,
    input  logic [NUM_UNITS-1:0]        release_i,
    output logic                        gnt_valid_o,
    output logic [CORE_W-1:0]           gnt_core_o,
    output logic [UNIT_W-1:0]           gnt_unit_o,
    output logic                        gnt_approx_o
);
    import fpa_pkg::*;

    logic [NUM_UNITS*VULN_W-1:0] snap;
    logic [NUM_UNITS*UNIT_W-1:0] order;
    logic [NUM_UNITS-1:0]        held_q;
    logic [NUM_UNITS-1:0]        elig [NUM_CORES];
    logic [NUM_CORES-1:0]        servable;
    logic                        win_any;
    logic [CORE_W-1:0]           win_idx;
    logic                        found;
    logic [UNIT_W-1:0]           unit_sel;
    logic [NUM_UNITS-1:0]        grant_vec;
    logic [VULN_W-1:0]           unit_vuln;
    logic [VULN_W-1:0]           win_thresh;
    fpa_mode_e                   mode;

    fpa_rank #(.NUM_UNITS(NUM_UNITS), .VULN_W(VULN_W)) i_rank (
        .clk      (clk),
        .rst_n    (rst_n),
        .publish_i(vuln_publish_i),
        .vuln_i   (vuln_i),
        .snap_o   (snap),
        .order_o  (order)
    );

    // Per-core eligible units: free and of the requested kind.
    always_comb begin
        for (int c = 0; c < NUM_CORES; c++) begin
            for (int u = 0; u < NUM_UNITS; u++) begin
                elig[c][u] = !unit_busy_i[u] && !held_q[u] &&
                    (unit_kind_i[u*KIND_W +: KIND_W] == req_kind_i[c*KIND_W +: KIND_W]);
            end
            servable[c] = req_valid_i[c] && (|elig[c]);
        end
    end

    fpa_rr #(.NUM_CORES(NUM_CORES)) i_rr (
        .clk      (clk),
        .rst_n    (rst_n),
        .req_i    (servable),
        .advance_i(gnt_valid_o),
        .any_o    (win_any),
        .idx_o    (win_idx)
    );

    fpa_walk #(.NUM_UNITS(NUM_UNITS)) i_walk (
        .order_i(order),
        .elig_i (elig[win_idx]),
        .found_o(found),
        .unit_o (unit_sel)
    );

    // Grant outputs and the mode decision against the winner's threshold.
    always_comb begin
        unit_vuln    = snap[unit_sel*VULN_W +: VULN_W];
        win_thresh   = req_thresh_i[win_idx*VULN_W +: VULN_W];
        gnt_valid_o  = win_any && found;
        gnt_core_o   = win_idx;
        gnt_unit_o   = unit_sel;
        mode         = (req_approx_i[win_idx] && (unit_vuln < win_thresh)) ? MODE_APPROX
                                                                             : MODE_ACCURATE;
        gnt_approx_o = gnt_valid_o && (mode == MODE_APPROX);
        grant_vec    = '0;
        if (gnt_valid_o) grant_vec[unit_sel] = 1'b1;
    end

    // Allocation state: set on grant, cleared on release.
    always_ff @(posedge clk) begin
        if (!rst_n) held_q <= '0;
        else        held_q <= (held_q & ~release_i) | grant_vec;
    end

    assert_grant_free_R4: assert property (@(posedge clk) disable iff (!rst_n)
        gnt_valid_o |-> (!unit_busy_i[gnt_unit_o] && !held_q[gnt_unit_o]));
    assert_kind_match_R5: assert property (@(posedge clk) disable iff (!rst_n)
        gnt_valid_o |-> (unit_kind_i[gnt_unit_o*KIND_W +: KIND_W] ==
                         req_kind_i[gnt_core_o*KIND_W +: KIND_W]));
    assert_grant_to_requester_R8: assert property (@(posedge clk) disable iff (!rst_n)
        gnt_valid_o |-> req_valid_i[gnt_core_o]);
    assert_approx_only_if_asked_R7: assert property (@(posedge clk) disable iff (!rst_n)
        gnt_approx_o |-> (gnt_valid_o && req_approx_i[gnt_core_o]));
    assert_grant_marks_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
        gnt_valid_o |=> held_q[$past(gnt_unit_o)]);
    for (genvar u = 0; u < NUM_UNITS; u++) begin : g_keep
        assert_held_kept_R10: assert property (@(posedge clk) disable iff (!rst_n)
            (held_q[u] && !release_i[u]) |=> held_q[u]);
    end

endmodule

// File: tb/test_fpu_alloc.sv
// Scoreboard bench: the driver queues the expected grant for each
// request, and the monitor compares grants against the queue.
module test_fpu_alloc;
    localparam int NC = 16, NU = 8, VW = 8, KW = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [NC-1:0]    req_v = '0;
    logic [NC*KW-1:0] req_k = '0;
    logic [NC-1:0]    req_a = '0;
    logic [NC*VW-1:0] req_t = '0;
    logic [NU*KW-1:0] ukind;
    logic [NU-1:0]    ubusy = '0;
    logic [NU*VW-1:0] vuln = '0;
    logic             pub = 1'b0;
    logic [NU-1:0]    rel = '0;
    logic             gv, ga;
    logic [3:0]       gc;
    logic [2:0]       gu;

    always #2.5 clk = ~clk;

    fpu_alloc i_fpu_alloc (
        .clk(clk), .rst_n(rst_n), .req_valid_i(req_v), .req_kind_i(req_k),
        .req_approx_i(req_a), .req_thresh_i(req_t), .unit_kind_i(ukind),
        .unit_busy_i(ubusy), .vuln_i(vuln), .vuln_publish_i(pub), .release_i(rel),
        .gnt_valid_o(gv), .gnt_core_o(gc), .gnt_unit_o(gu), .gnt_approx_o(ga)
    );

    typedef struct { int core; int unit; bit approx; string tag; } exp_t;
    exp_t exp_q [$];
    int checks = 0, errors = 0;
    bit drop_pend = 0;
    int drop_c = 0;

    // Monitor: compare each grant with the head of the queue.
    always @(negedge clk) begin
        if (rst_n && gv) begin
            checks++;
            if (exp_q.size() == 0) begin
                errors++;
                $display("FAIL unexpected grant: actual core=%0d unit=%0d expected none", gc, gu);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                if (gc != e.core || gu != e.unit || ga != e.approx) begin
                    errors++;
                    $display("FAIL %s: actual core=%0d unit=%0d approx=%0d expected core=%0d unit=%0d approx=%0d",
                             e.tag, gc, gu, ga, e.core, e.unit, e.approx);
                end
            end
            drop_c    = gc;
            drop_pend = 1;
        end
    end

    // Core model: a granted core drops its request after the edge.
    always @(posedge clk) begin
        if (drop_pend) begin
            drop_pend = 0;
            #1 req_v[drop_c] = 1'b0;
        end
    end

    task automatic step();
        @(posedge clk); #1;
    endtask

    task automatic issue(int c, int k, bit a, int t, int eu, bit ea, string tag);
        exp_t e;
        e.core = c; e.unit = eu; e.approx = ea; e.tag = tag;
        exp_q.push_back(e);
        req_k[c*KW +: KW] = KW'(k);
        req_a[c] = a;
        req_t[c*VW +: VW] = VW'(t);
        req_v[c] = 1'b1;
    endtask

    task automatic check_idle(int n, string tag);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            checks++;
            if (gv !== 1'b0) begin
                errors++;
                $display("FAIL %s: actual gnt_valid=%0b expected 0", tag, gv);
            end
        end
    endtask

    task automatic drain(string tag);
        for (int i = 0; i < 20 && exp_q.size() != 0; i++) step();
        step();
        checks++;
        if (exp_q.size() != 0) begin
            errors++;
            $display("FAIL %s: actual pending=%0d expected 0", tag, exp_q.size());
        end
    endtask

    task automatic release_unit(int u);
        rel[u] = 1'b1; step(); rel[u] = 1'b0;
    endtask

    task automatic publish();
        pub = 1'b1; step(); pub = 1'b0; step();
    endtask

    task automatic set_vuln(int u, int v);
        vuln[u*VW +: VW] = VW'(v);
    endtask

    initial begin
        for (int u = 0; u < NU; u++) ukind[u*KW +: KW] = (u < 4) ? 2'd0 : 2'd1;
        check_idle(2, "R1 in reset");
        step(); rst_n = 1'b1;
        check_idle(2, "R1 after reset");
        // R1: default ranking is index order.
        issue(3, 0, 0, 0, 0, 0, "R1 index order");
        drain("R1");
        release_unit(0);
        // Kind 0: u1=10 u3=10 u2=30 u0=40; kind 1: u4=5 u7=5 u6=20 u5=50.
        set_vuln(0, 40); set_vuln(1, 10); set_vuln(2, 30); set_vuln(3, 10);
        set_vuln(4, 5);  set_vuln(5, 50); set_vuln(6, 20); set_vuln(7, 5);
        publish();
        issue(2, 0, 0, 0, 1, 0, "R2 R3 lowest then index");
        drain("R2");
        issue(5, 0, 1, 11, 3, 1, "R7 below threshold");
        drain("R7");
        issue(6, 0, 1, 30, 2, 0, "R7 equal threshold");
        drain("R7");
        // R4/R6/R5: u0 externally busy, rest held; kind 1 free but unusable.
        ubusy[0] = 1'b1;
        issue(7, 0, 0, 0, 3, 0, "R6 R11 served after release");
        check_idle(3, "R6 R4 R5 no free unit of kind");
        step();
        release_unit(3);
        drain("R6");
        // R8: three waiting cores after last grant to core 7.
        issue(9, 1, 0, 0, 4, 0, "R8 first above last");
        issue(12, 1, 0, 0, 7, 0, "R8 second");
        issue(1, 1, 0, 0, 6, 0, "R8 R9 wrap-around");
        drain("R8");
        // R10: republish; held units stay held.
        for (int u = 0; u < NU; u++) set_vuln(u, 100);
        set_vuln(5, 0);
        publish();
        issue(0, 1, 1, 1, 5, 1, "R10 new ranking approx");
        drain("R10");
        issue(4, 1, 0, 0, 7, 0, "R11 released unit");
        check_idle(2, "R10 held kept after publish");
        step();
        release_unit(7);
        drain("R11");
        check_idle(2, "R9 no regrant");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    // Watchdog.
    initial begin
        repeat (20000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule